// File: doc/BRIEF.md
# Shared-Memory VGA Scanout Controller

This block scans a 640x480 picture out of an external byte-wide asynchronous static RAM and produces the sync, enable and pixel signals for a VGA monitor. It runs entirely on the pixel clock, nominally 25.175 MHz. A horizontal position counter spans a full scan line of 800 clocks. A line counter steps once per line and spans 525 lines per frame. The picture is drawn while both positions lie inside the visible area. During that window a linear scan pointer walks through the memory one byte per pixel. Each byte read back is registered and presented as the pixel for exactly one clock.

The same memory bus also serves a host that fills the frame store. Host writes use a valid/ready interface. The block raises ready only outside the drawing window. A request made while the picture is being drawn therefore stalls and completes in the first blanking cycle. The write-data drivers are switched on only in the cycle of an accepted write, so a scanout read never contends with them. Colour decoding, the DAC and any drawing logic belong to the host side.

All dimensions are parameters. The defaults give the standard 640x480 mode, with active-low syncs.

Top module: `vga_fb_scanout`

## Requirements
- R1: The horizontal position counts 0 to H_TOTAL-1 (800 by default) and wraps. `line_active` is high for positions 0 to H_VIS-1. Like every video output, it appears one clock after the counter position it describes.
- R2: The line counter advances only when the horizontal position wraps from H_TOTAL-1 to 0. It counts 0 to V_TOTAL-1 (525 by default) and then wraps to 0.
- R3: `hsync_n` is low (active) for horizontal positions H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1. `vsync_n` is low on lines V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1. Both are high everywhere else.
- R4: The drawing window is horizontal position < H_VIS together with line < V_VIS. `draw_en` shows that window, delayed by one clock.
- R5: Inside the window, `sram_addr` carries the scan pointer. The pointer is 0 for the first pixel of every frame and rises by 1 for each drawn pixel.
- R6: `pixel` is the byte on `sram_rdata` registered one clock after a drawn position. It is forced to 0 one clock after every position outside the window.
- R7: `wr_ready` is high exactly when the current position is outside the drawing window. A write transfers in a cycle with `wr_valid` and `wr_ready` both high. In that same cycle, `sram_addr` = `wr_addr`, `sram_we_n` = 0, `sram_wdata_oe` = 1 and `sram_wdata` = `wr_data`.
- R8: `sram_wdata_oe` is 1 and `sram_we_n` is 0 only in a write-transfer cycle. `sram_oe_n` is 0 exactly inside the drawing window.
- R9: Back-pressure: a request held while drawing receives no transfer. If it is still held, it completes in the first cycle after the window closes. The host must keep its address and data stable until the transfer.
- R10: While `rst_n` is low, both counters and the scan pointer are 0. `hsync_n` and `vsync_n` are 1, and `line_active`, `draw_en` and `pixel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Host write accepted this cycle when valid |
| wr_addr | input | 20 | Host write byte address |
| wr_data | input | 8 | Host write byte |
| sram_addr | output | 20 | Memory address |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory read enable, active low |
| sram_wdata | output | 8 | Write data toward the tristate driver |
| sram_wdata_oe | output | 1 | Tristate driver enable |
| sram_rdata | input | 8 | Data read from memory |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| line_active | output | 1 | Horizontal active enable |
| draw_en | output | 1 | Picture being drawn |
| pixel | output | 8 | Registered pixel byte |

## Verification
Two things can fall in the same cycle: a host write request, and the scanout's claim on the bus at the first pixel of a line. The bench issues a stream of writes with irregular gaps, so requests land inside the window, on its last blanking cycle and on its first drawn cycle. A behavioural position-and-memory model predicts the bus owner, the strobes and the displayed byte on every clock. Any write that leaks into the window, and any pixel that shows a byte one position off, is reported.

// File: rtl/vga_fb_pkg.sv
package vga_fb_pkg;
  typedef struct packed {
    logic hs_n;
    logic vs_n;
    logic hact;
    logic draw;
  } vid_ctl_t;

  function automatic logic in_span(input int pos, input int lo, input int len);
    return (pos >= lo) && (pos < lo + len);
  endfunction
endpackage

// File: rtl/vga_fb_timing.sv
module vga_fb_timing
  import vga_fb_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic     clk,
  input  logic     rst_n,
  output vid_ctl_t ctl,
  output logic     frame_end
);
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HCW = $clog2(H_TOTAL);
  localparam int VCW = $clog2(V_TOTAL);

  logic [HCW-1:0] hpos;
  logic [VCW-1:0] vpos;
  logic           h_last, v_last;

  assign h_last = (hpos == HCW'(H_TOTAL - 1));
  assign v_last = (vpos == VCW'(V_TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else begin
      hpos <= h_last ? '0 : hpos + 1'b1;
      if (h_last) vpos <= v_last ? '0 : vpos + 1'b1;
    end
  end

  always_comb begin
    ctl.hact = (int'(hpos) < H_VIS);
    ctl.draw = ctl.hact && (int'(vpos) < V_VIS);
    ctl.hs_n = !in_span(int'(hpos), H_VIS + H_FP, H_SYNC);
    ctl.vs_n = !in_span(int'(vpos), V_VIS + V_FP, V_SYNC);
  end

  assign frame_end = h_last && v_last;

  // R1: the position wraps after its last value
  a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    h_last |=> (hpos == '0));
  // R2: the line counter holds except at a line wrap
  a_r2_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !h_last |=> $stable(vpos));
endmodule

// File: rtl/vga_fb_scan_ptr.sv
module vga_fb_scan_ptr #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          draw,
  input  logic          frame_end,
  output logic [AW-1:0] scan_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         scan_addr <= '0;
    else if (frame_end) scan_addr <= '0;
    else if (draw)      scan_addr <= scan_addr + 1'b1;
  end

  // R5: one step per drawn pixel
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    draw |=> (scan_addr == $past(scan_addr) + 1'b1));
  // R5: the pointer restarts at every frame
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (scan_addr == '0));
endmodule

// File: rtl/vga_fb_bus_mux.sv
module vga_fb_bus_mux #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          draw,
  input  logic [AW-1:0] scan_addr,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_wdata,
  output logic          sram_wdata_oe
);
  logic host_go;

  assign wr_ready      = !draw;
  assign host_go       = wr_valid && wr_ready;
  assign sram_addr     = draw ? scan_addr : wr_addr;
  assign sram_oe_n     = !draw;
  assign sram_we_n     = !host_go;
  assign sram_wdata_oe = host_go;
  assign sram_wdata    = wr_data;

  // R8: the drivers stay off while the picture is read
  a_r8_no_drive_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_wdata_oe);
  // R7: a write strobe always carries enabled drivers and the host address
  a_r7_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_wdata_oe && sram_addr == wr_addr));
endmodule

// File: rtl/vga_fb_pixel_out.sv
module vga_fb_pixel_out
  import vga_fb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vid_ctl_t      ctl,
  input  logic [DW-1:0] rdata,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          line_active,
  output logic          draw_en,
  output logic [DW-1:0] pixel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_n     <= 1'b1;
      vsync_n     <= 1'b1;
      line_active <= 1'b0;
      draw_en     <= 1'b0;
      pixel       <= '0;
    end else begin
      hsync_n     <= ctl.hs_n;
      vsync_n     <= ctl.vs_n;
      line_active <= ctl.hact;
      draw_en     <= ctl.draw;
      pixel       <= ctl.draw ? rdata : '0;
    end
  end

  // R6: blank positions show a zero byte
  a_r6_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.draw |=> (pixel == '0));
  // R6: a drawn position shows the byte read in that cycle
  a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.draw |=> (pixel == $past(rdata)));
  // R4: drawing implies the horizontal active enable
  a_r4_draw_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    draw_en |-> line_active);
endmodule

// File: rtl/vga_fb_scanout.sv
module vga_fb_scanout
  import vga_fb_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int AW     = 20,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_wdata,
  output logic          sram_wdata_oe,
  input  logic [DW-1:0] sram_rdata,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          line_active,
  output logic          draw_en,
  output logic [DW-1:0] pixel
);
  vid_ctl_t      ctl;
  logic          frame_end;
  logic [AW-1:0] scan_addr;

  vga_fb_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .frame_end(frame_end)
  );

  vga_fb_scan_ptr #(.AW(AW)) u_scan (
    .clk(clk), .rst_n(rst_n), .draw(ctl.draw), .frame_end(frame_end),
    .scan_addr(scan_addr)
  );

  vga_fb_bus_mux #(.AW(AW), .DW(DW)) u_mux (
    .clk(clk), .rst_n(rst_n), .draw(ctl.draw), .scan_addr(scan_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .sram_addr(sram_addr), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_wdata(sram_wdata),
    .sram_wdata_oe(sram_wdata_oe)
  );

  vga_fb_pixel_out #(.DW(DW)) u_pix (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .rdata(sram_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .line_active(line_active),
    .draw_en(draw_en), .pixel(pixel)
  );

  // R9: no write is accepted while the window is open
  a_r9_stall_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!wr_ready && sram_we_n));
endmodule

// File: tb/tb_vga_fb_scanout.sv
module tb_vga_fb_scanout;
  localparam int CLK_PERIOD = 10;
  localparam int HV = 8, HF = 2, HS = 3, HB = 2;
  localparam int VV = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [19:0] sram_addr;
  logic        sram_we_n, sram_oe_n, sram_wdata_oe;
  logic [7:0]  sram_wdata, sram_rdata;
  logic        hsync_n, vsync_n, line_active, draw_en;
  logic [7:0]  pixel;

  logic [7:0] mem [256];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  int h = 0, v = 0, scan = 0;
  logic e_hs = 1, e_vs = 1, e_la = 0, e_de = 0;
  logic [7:0] e_pix = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_fb_scanout #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .sram_addr(sram_addr),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_wdata(sram_wdata),
    .sram_wdata_oe(sram_wdata_oe), .sram_rdata(sram_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .line_active(line_active),
    .draw_en(draw_en), .pixel(pixel)
  );

  // memory model: asynchronous read, write at the end of the strobe cycle
  assign sram_rdata = mem[sram_addr[7:0]];
  always @(posedge clk) if (!sram_we_n && sram_wdata_oe) mem[sram_addr[7:0]] <= sram_wdata;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", tag, act, exp, h, v);
    end
  endtask

  // reference model, advanced at each edge from its own position
  always @(posedge clk) begin
    if (rst_n) begin
      bit dr;
      dr = (h < HV) && (v < VV);
      e_hs = !(h >= HV + HF && h < HV + HF + HS);
      e_vs = !(v >= VV + VF && v < VV + VF + VS);
      e_la = (h < HV);
      e_de = dr;
      e_pix = dr ? mem[scan[7:0]] : 8'h00;
      if (h == HT - 1 && v == VT - 1) scan = 0;
      else if (dr) scan++;
      if (h == HT - 1) begin
        h = 0;
        v = (v == VT - 1) ? 0 : v + 1;
      end else h++;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit dr, go;
      dr = (h < HV) && (v < VV);
      go = !dr && wr_valid;
      check("R3 hsync_n", hsync_n, e_hs);
      check("R3 vsync_n", vsync_n, e_vs);
      check("R1 line_active", line_active, e_la);
      check("R4 draw_en", draw_en, e_de);
      check("R6 pixel", pixel, e_pix);
      check("R7 wr_ready", wr_ready, !dr);
      check("R8 sram_oe_n", sram_oe_n, !dr);
      check("R8 sram_we_n", sram_we_n, !go);
      check("R8 sram_wdata_oe", sram_wdata_oe, go);
      if (dr) check("R5 scan address", sram_addr, scan);
      else if (go) begin
        check("R7 write address", sram_addr, wr_addr);
        check("R7 write data", sram_wdata, wr_data);
      end
    end
  end

  task automatic host_write(input logic [19:0] a, input logic [7:0] d, input int gap);
    bit got;
    bit saw_stall;
    saw_stall = 0;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    forever begin
      @(negedge clk); got = wr_ready;
      if (!got) saw_stall = 1;
      @(posedge clk);
      if (got) break;
    end
    #1 wr_valid = 1'b0;
    if (saw_stall) begin
      // R9: the stalled request completed once the window closed
      check("R9 stalled write landed", mem[a[7:0]], d);
    end
    repeat (gap) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    #(CLK_PERIOD * 3 + 1);
    // R10: reset values
    check("R10 hsync_n", hsync_n, 1);
    check("R10 vsync_n", vsync_n, 1);
    check("R10 line_active", line_active, 0);
    check("R10 draw_en", draw_en, 0);
    check("R10 pixel", pixel, 0);
    check("R10 scan address", sram_addr, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (HT * VT) @(posedge clk);
    #1;
    for (int i = 0; i < 32; i++) host_write(20'(i), 8'(i * 7 + 3), i % 4);
    host_write(20'hA50C3, 8'hE1, 1);
    repeat (HT * VT + 5) @(posedge clk);
    #1;
    for (int i = 0; i < 12; i++) host_write(20'(i * 3), 8'(8'hC0 + i), (i * 5) % 7);
    repeat (HT * VT * 2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: run did not end");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule